// File: doc/BRIEF.md
# Interrupt Priority Vector Decoder

This block sits in front of a small CPU and turns a set of pending interrupt request lines into the 16-bit address of the service routine to run. Request lines have a fixed priority by index. One maskable source can be raised above all the others through a promotion select. When that happens, the real-time-interrupt source moves into the priority slot the promoted source left. Decoded reset causes (power-on, clock monitor, watchdog) have their own vectors, and these override every interrupt.

The winner is not frozen when the CPU first notices an interrupt. It is decided in the cycle in which the CPU pulses its vector-request strobe. A request of higher priority that arrives in between therefore takes over. The block also records the winner of every cycle that has a pending request. If all requests have gone by the time of the strobe, it returns the last recorded winner. If nothing has been pending at any time since reset, it returns the software-interrupt vector.

Top module: `ivd_vector_dec`

## Requirements
- R1: With promotion off, the lowest-indexed pending request wins, and the vector of source i is `IRQ_BASE - 2*i` (defaults: base 16'hFFF0, so source 0 gives 16'hFFF0 and source 15 gives 16'hFFD2).
- R2: With `promo_en` high, a pending request on source `promo_idx` wins over every other pending request and returns its own vector.
- R3: While a source p is promoted, the real-time-interrupt source (`RTI_IDX`, default 5) takes priority position p. Its own position is left empty. It still returns its own vector (default 16'hFFE6).
- R4: The vector reflects the requests present in the strobe cycle, not those present when an interrupt first appeared.
- R5: `vec_valid` is high exactly in the cycle after a cycle with `vec_req` high. `vec_out` changes only then and holds its value otherwise.
- R6: If no request is pending in the strobe cycle, but one has been pending since reset, the vector is that of the winner in the most recent cycle that had a pending request.
- R7: If no request has been pending since reset and no reset cause is active, the strobe returns the software-interrupt vector (default 16'hFFF6).
- R8: Any active reset cause overrides interrupts. The order is power-on (16'hFFFE), then clock monitor (16'hFFFC), then watchdog (16'hFFFA).
- R9: After reset, `vec_out` is 0 and `vec_valid` is 0.
- R10: With `promo_en` low, `promo_idx` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_IRQ | Pending request lines; bit i is source i |
| promo_en | input | 1 | Enables promotion of one source |
| promo_idx | input | IDX_W | Index of the promoted source |
| vec_req | input | 1 | CPU vector-request strobe |
| rst_por | input | 1 | Power-on / normal reset cause |
| rst_clkmon | input | 1 | Clock-monitor reset cause |
| rst_wdog | input | 1 | Watchdog reset cause |
| vec_out | output | VEC_W | Registered service-routine address |
| vec_valid | output | 1 | High in the cycle `vec_out` carries a fresh answer |

## Verification
Every answer arrives one clock edge after the strobe cycle. The bench raises `vec_req` on a falling edge and samples `vec_out` and `vec_valid` on the next falling edge. It then looks one more cycle later to confirm that `vec_valid` has dropped. The record of the last winner is taken at each edge, so each stimulus is held for one full cycle before the strobe. This lets the history settle, and the fallback cases can be predicted exactly.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

   typedef enum logic [1:0] {
      RK_NONE   = 2'd0,
      RK_WDOG   = 2'd1,
      RK_CLKMON = 2'd2,
      RK_POR    = 2'd3
   } rst_kind_e;

   // Source address: base minus two bytes per index step
   function automatic logic [15:0] src_vector(input logic [15:0] base,
                                              input logic [15:0] idx);
      return base - (idx << 1);
   endfunction

endpackage

// File: rtl/ivd_prio_sel.sv
module ivd_prio_sel #(
   parameter int N_IRQ      = 16,
   parameter int IDX_W      = 4,
   parameter int RTI_IDX    = 5,
   parameter bit PROMO_IMPL = 1'b1
) (
   input  logic [N_IRQ-1:0] req,
   input  logic             promo_en,
   input  logic [IDX_W-1:0] promo_idx,
   output logic             hit,
   output logic [IDX_W-1:0] win_idx
);

   localparam logic [IDX_W-1:0] RTI_I = IDX_W'(RTI_IDX);

   logic             base_hit;
   logic [IDX_W-1:0] base_idx;

   // Plain fixed order: lowest index first
   always_comb begin
      base_hit = |req;
      base_idx = '0;
      for (int k = N_IRQ - 1; k >= 0; k--) begin
         if (req[k]) base_idx = IDX_W'(k);
      end
   end

   generate
      if (PROMO_IMPL) begin : g_promo
         logic             promo_ok;
         logic             promo_pend;
         logic [N_IRQ-1:0] slot_req;
         logic             slot_hit;
         logic [IDX_W-1:0] slot_idx;

         assign promo_ok   = promo_en && (int'(promo_idx) < N_IRQ);
         assign promo_pend = promo_ok && req[promo_idx];

         // Remapped slots: RTI fills the vacated position
         always_comb begin
            slot_req = req;
            if (promo_ok) begin
               slot_req[RTI_IDX]   = 1'b0;
               slot_req[promo_idx] = req[RTI_IDX];
            end
         end

         always_comb begin
            slot_hit = |slot_req;
            slot_idx = '0;
            for (int k = N_IRQ - 1; k >= 0; k--) begin
               if (slot_req[k]) begin
                  if (promo_ok && (IDX_W'(k) == promo_idx)) slot_idx = RTI_I;
                  else                                      slot_idx = IDX_W'(k);
               end
            end
         end

         always_comb begin
            if (!promo_ok) begin
               hit     = base_hit;
               win_idx = base_idx;
            end else if (promo_pend) begin
               hit     = 1'b1;
               win_idx = promo_idx;
            end else begin
               hit     = slot_hit;
               win_idx = slot_idx;
            end
         end
      end else begin : g_fixed
         logic unused_promo;
         assign unused_promo = promo_en ^ (^promo_idx);
         assign hit     = base_hit;
         assign win_idx = base_idx;
      end
   endgenerate

endmodule

// File: rtl/ivd_last_valid.sv
module ivd_last_valid #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [IDX_W-1:0] win_idx,
   output logic             ever_pend,
   output logic [IDX_W-1:0] last_idx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ever_pend <= 1'b0;
         last_idx  <= '0;
      end else if (hit) begin
         ever_pend <= 1'b1;
         last_idx  <= win_idx;
      end
   end

endmodule

// File: rtl/ivd_reset_sel.sv
module ivd_reset_sel
   import ivd_pkg::*;
(
   input  logic      rst_por,
   input  logic      rst_clkmon,
   input  logic      rst_wdog,
   output rst_kind_e kind
);

   always_comb begin
      if (rst_por)         kind = RK_POR;
      else if (rst_clkmon) kind = RK_CLKMON;
      else if (rst_wdog)   kind = RK_WDOG;
      else                 kind = RK_NONE;
   end

endmodule

// File: rtl/ivd_vector_dec.sv
module ivd_vector_dec
   import ivd_pkg::*;
#(
   parameter int               N_IRQ      = 16,
   parameter int               IDX_W      = 4,
   parameter int               VEC_W      = 16,
   parameter int               RTI_IDX    = 5,
   parameter bit               PROMO_IMPL = 1'b1,
   parameter logic [VEC_W-1:0] IRQ_BASE   = 16'hFFF0,
   parameter logic [VEC_W-1:0] SWI_VEC    = 16'hFFF6,
   parameter logic [VEC_W-1:0] WDOG_VEC   = 16'hFFFA,
   parameter logic [VEC_W-1:0] CLKMON_VEC = 16'hFFFC,
   parameter logic [VEC_W-1:0] POR_VEC    = 16'hFFFE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             promo_en,
   input  logic [IDX_W-1:0] promo_idx,
   input  logic             vec_req,
   input  logic             rst_por,
   input  logic             rst_clkmon,
   input  logic             rst_wdog,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid
);

   localparam int MAX_SRC = (1 << IDX_W);

   generate
      if (N_IRQ < 2 || N_IRQ > MAX_SRC) begin : g_bad_n
         $error("N_IRQ must lie in 2..2**IDX_W");
      end
      if (RTI_IDX < 0 || RTI_IDX >= N_IRQ) begin : g_bad_rti
         $error("RTI_IDX must index an existing source");
      end
      if (VEC_W != 16 || IDX_W + 1 > VEC_W) begin : g_bad_w
         $error("VEC_W must be 16 and wider than IDX_W");
      end
   endgenerate

   logic             cur_hit;
   logic [IDX_W-1:0] cur_idx;
   logic             ever_pend;
   logic [IDX_W-1:0] last_idx;
   rst_kind_e        rkind;
   logic [VEC_W-1:0] next_vec;

   ivd_prio_sel #(
      .N_IRQ     (N_IRQ),
      .IDX_W     (IDX_W),
      .RTI_IDX   (RTI_IDX),
      .PROMO_IMPL(PROMO_IMPL)
   ) u_prio (
      .req      (irq_req),
      .promo_en (promo_en),
      .promo_idx(promo_idx),
      .hit      (cur_hit),
      .win_idx  (cur_idx)
   );

   ivd_last_valid #(
      .IDX_W(IDX_W)
   ) u_last (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (cur_hit),
      .win_idx  (cur_idx),
      .ever_pend(ever_pend),
      .last_idx (last_idx)
   );

   ivd_reset_sel u_rsel (
      .rst_por   (rst_por),
      .rst_clkmon(rst_clkmon),
      .rst_wdog  (rst_wdog),
      .kind      (rkind)
   );

   // Late selection: evaluated in the strobe cycle itself
   always_comb begin
      unique case (rkind)
         RK_POR:    next_vec = POR_VEC;
         RK_CLKMON: next_vec = CLKMON_VEC;
         RK_WDOG:   next_vec = WDOG_VEC;
         default: begin
            if (cur_hit)        next_vec = src_vector(IRQ_BASE, 16'(cur_idx));
            else if (ever_pend) next_vec = src_vector(IRQ_BASE, 16'(last_idx));
            else                next_vec = SWI_VEC;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= vec_req;
         if (vec_req) vec_out <= next_vec;
      end
   end

endmodule

// File: rtl/ivd_vector_dec_chk.sv
module ivd_vector_dec_chk #(
   parameter int               N_IRQ      = 16,
   parameter int               IDX_W      = 4,
   parameter int               VEC_W      = 16,
   parameter logic [VEC_W-1:0] IRQ_BASE   = 16'hFFF0,
   parameter logic [VEC_W-1:0] SWI_VEC    = 16'hFFF6,
   parameter logic [VEC_W-1:0] WDOG_VEC   = 16'hFFFA,
   parameter logic [VEC_W-1:0] POR_VEC    = 16'hFFFE
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IRQ-1:0] irq_req,
   input logic             promo_en,
   input logic [IDX_W-1:0] promo_idx,
   input logic             vec_req,
   input logic             rst_por,
   input logic             rst_clkmon,
   input logic             rst_wdog,
   input logic             ever_pend,
   input logic [VEC_W-1:0] vec_out,
   input logic             vec_valid
);

   logic no_rst;
   assign no_rst = !rst_por && !rst_clkmon && !rst_wdog;

   a_r5_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |=> vec_valid);

   a_r5_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |=> !vec_valid);

   a_r5_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |=> $stable(vec_out));

   a_r8_por_first: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && rst_por) |=> (vec_out == POR_VEC));

   a_r8_wdog_last: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && rst_wdog && !rst_por && !rst_clkmon) |=> (vec_out == WDOG_VEC));

   a_r7_swi_default: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && no_rst && (irq_req == '0) && !ever_pend) |=> (vec_out == SWI_VEC));

   a_r1_source0_top: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && no_rst && !promo_en && irq_req[0]) |=> (vec_out == IRQ_BASE));

   a_r2_promoted_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && no_rst && promo_en && (int'(promo_idx) < N_IRQ) && irq_req[promo_idx])
      |=> (vec_out == IRQ_BASE - VEC_W'({$past(promo_idx), 1'b0})));

endmodule

bind ivd_vector_dec ivd_vector_dec_chk #(
   .N_IRQ   (N_IRQ),
   .IDX_W   (IDX_W),
   .VEC_W   (VEC_W),
   .IRQ_BASE(IRQ_BASE),
   .SWI_VEC (SWI_VEC),
   .WDOG_VEC(WDOG_VEC),
   .POR_VEC (POR_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .promo_en  (promo_en),
   .promo_idx (promo_idx),
   .vec_req   (vec_req),
   .rst_por   (rst_por),
   .rst_clkmon(rst_clkmon),
   .rst_wdog  (rst_wdog),
   .ever_pend (ever_pend),
   .vec_out   (vec_out),
   .vec_valid (vec_valid)
);

// File: tb/tb_ivd_vector_dec.sv
module tb_ivd_vector_dec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic        promo_en = 1'b0;
   logic [3:0]  promo_idx = '0;
   logic        vec_req = 1'b0;
   logic        rst_por = 1'b0;
   logic        rst_clkmon = 1'b0;
   logic        rst_wdog = 1'b0;
   logic [15:0] vec_out;
   logic        vec_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ivd_vector_dec dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .promo_en(promo_en),
      .promo_idx(promo_idx), .vec_req(vec_req), .rst_por(rst_por),
      .rst_clkmon(rst_clkmon), .rst_wdog(rst_wdog),
      .vec_out(vec_out), .vec_valid(vec_valid)
   );

   // entry: irq[39:24] promo_en[23] promo_idx[22:19] {por,cm,wd}[18:16] expected[15:0]
   localparam int NV = 13;
   localparam logic [39:0] VEC_TAB [NV] = '{
      {16'h0001, 1'b0, 4'd0,  3'b000, 16'hFFF0},  // R1 source 0
      {16'h8000, 1'b0, 4'd0,  3'b000, 16'hFFD2},  // R1 source 15
      {16'h0480, 1'b0, 4'd0,  3'b000, 16'hFFE2},  // R1 7 beats 10
      {16'h0481, 1'b1, 4'd10, 3'b000, 16'hFFDC},  // R2 promoted 10
      {16'h0481, 1'b0, 4'd10, 3'b000, 16'hFFF0},  // R10 idx ignored
      {16'h0028, 1'b1, 4'd2,  3'b000, 16'hFFE6},  // R3 RTI in slot 2 beats 3
      {16'h0022, 1'b1, 4'd2,  3'b000, 16'hFFEE},  // R3 1 beats RTI in slot 2
      {16'h0025, 1'b1, 4'd2,  3'b000, 16'hFFEC},  // R2 promoted 2 beats 0
      {16'h0030, 1'b1, 4'd12, 3'b000, 16'hFFE8},  // R3 RTI moved down to 12
      {16'h0028, 1'b0, 4'd2,  3'b000, 16'hFFEA},  // R10 no promo, 3 wins
      {16'h0001, 1'b0, 4'd0,  3'b001, 16'hFFFA},  // R8 watchdog
      {16'h0001, 1'b0, 4'd0,  3'b011, 16'hFFFC},  // R8 clkmon over wdog
      {16'h0001, 1'b1, 4'd0,  3'b111, 16'hFFFE}   // R8 por over all
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] irq, input logic pen, input logic [3:0] pidx,
                        input logic [2:0] rsts);
      @(negedge clk);
      irq_req = irq; promo_en = pen; promo_idx = pidx;
      {rst_por, rst_clkmon, rst_wdog} = rsts;
   endtask

   // pulse the strobe for one cycle, sample the answer one edge later
   task automatic strobe(input string req, input logic [15:0] exp);
      @(negedge clk);
      vec_req = 1'b1;
      @(negedge clk);
      vec_req = 1'b0;
      check({req, " valid"}, 32'(vec_valid), 32'd1);
      check(req, 32'(vec_out), 32'(exp));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq_req = '0; promo_en = 1'b0; promo_idx = '0; vec_req = 1'b0;
      {rst_por, rst_clkmon, rst_wdog} = 3'b000;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      check("R9 out", 32'(vec_out), 32'h0);
      check("R9 valid", 32'(vec_valid), 32'd0);

      // never pending since reset
      strobe("R7", 16'hFFF6);
      @(negedge clk);
      check("R5 valid drops", 32'(vec_valid), 32'd0);
      check("R5 hold", 32'(vec_out), 32'hFFF6);

      for (int i = 0; i < NV; i++) begin
         apply(VEC_TAB[i][39:24], VEC_TAB[i][23], VEC_TAB[i][22:19], VEC_TAB[i][18:16]);
         strobe($sformatf("table %0d", i), VEC_TAB[i][15:0]);
      end

      // R6: request vanishes before the strobe
      apply(16'h0200, 1'b0, 4'd0, 3'b000);
      apply(16'h0000, 1'b0, 4'd0, 3'b000);
      strobe("R6 last valid", 16'hFFDE);

      // R4: higher priority appears in the strobe cycle
      apply(16'h0040, 1'b0, 4'd0, 3'b000);
      @(negedge clk);
      irq_req = 16'h0042;
      vec_req = 1'b1;
      @(negedge clk);
      vec_req = 1'b0;
      check("R4 late pick", 32'(vec_out), 32'hFFEE);

      // R7 after a new reset clears history
      do_reset();
      strobe("R7 after reset", 16'hFFF6);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule